// File: doc/BRIEF.md
# Ethernet Transmit Pause-Frame Controller

This block sits beside a MAC transmitter and decides when a flow-control pause frame must go out and which 16-bit pause-time value it carries. It does not build or serialise the frame. It raises a request toward the transmit path and holds the request until the transmit path acknowledges it.

A request can come from two sources. Software can fire a single-cycle trigger, which requests one frame with the configured pause time. The block can also watch the receive-FIFO byte count and request frames on its own. When the fill rises above an upper threshold, the block enters a paused state and requests a pause. While it stays paused, a resend timer counts pause-quantum strobes and re-checks the fill each time the timer runs out. When the fill falls below a lower threshold, the block leaves the paused state and requests a zero-time frame, unless zero frames are disabled.

Both sources are active only while flow control is enabled and the link is full duplex. A busy flag tells software that its trigger has not yet been acknowledged.

Top module: `pause_tx_ctrl`

## Requirements
- R1: While `cfg_fc_en` is 0 or `cfg_full_duplex` is 0, no new request is raised. Triggers and FIFO levels seen in that time are dropped, and the paused state is cleared.
- R2: A software trigger that finds no request outstanding raises `req_valid` on the next clock edge, with `req_time` equal to `cfg_pause_time`.
- R3: A software trigger with `cfg_pause_time` equal to 0 requests a frame whose `req_time` is 0.
- R4: When the block is not paused and `fifo_level` is strictly greater than `cfg_thr_on`, the block becomes paused and requests a frame carrying `cfg_pause_time` two edges later, if the request path is idle.
- R5: Each automatic pause loads the resend timer with `cfg_resend_ivl`. The timer counts down one per cycle in which `quanta_tick` is high, and it expires one edge after it reaches 0. On expiry the timer reloads, and a new pause frame is requested only if `fifo_level` is still above `cfg_thr_on`.
- R6: When the block is paused and `fifo_level` is strictly below `cfg_thr_off`, the block leaves the paused state and requests a frame with `req_time` equal to 0. When `cfg_no_zero` is 1, it leaves the paused state without requesting a frame.
- R7: While `fifo_level` lies between `cfg_thr_off` and `cfg_thr_on`, both bounds included, the paused or unpaused state does not change.
- R8: `sw_busy` rises on the edge after an accepted trigger. It stays high until the software request is acknowledged. A trigger that arrives while a request is outstanding is kept and sent after the acknowledge.
- R9: When a software trigger and an automatic event coincide, the software frame is requested first, and the automatic frame follows after the acknowledge.
- R10: `req_valid` and `req_time` hold steady until `req_ack` is seen. `req_valid` falls on the edge after the acknowledge, and no new request rises on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fc_en | input | 1 | Transmit flow-control enable |
| cfg_full_duplex | input | 1 | 1 when the link is full duplex |
| cfg_pause_time | input | 16 | Pause time placed in non-zero frames |
| cfg_resend_ivl | input | RESEND_W | Resend interval, in quanta |
| cfg_thr_on | input | LVL_W | Activate threshold |
| cfg_thr_off | input | LVL_W | Deactivate threshold |
| cfg_no_zero | input | 1 | Suppresses zero-time frames on deactivation |
| sw_trig | input | 1 | Software trigger pulse |
| fifo_level | input | LVL_W | Receive-FIFO byte count |
| quanta_tick | input | 1 | Strobe once per 512 bit times |
| req_ack | input | 1 | Transmit path accepts the request |
| req_valid | output | 1 | Pause frame requested |
| req_time | output | 16 | Pause time for the requested frame |
| sw_busy | output | 1 | Software request not yet acknowledged |

## Verification
A software trigger shows on `req_valid` one edge after it is sampled. A threshold crossing takes two edges, one for the level monitor register and one for the request register. A timer expiry takes two edges after the strobe that brings the count to zero, and the acknowledge drops `req_valid` on the next edge. The bench drives its inputs 1 ns after a rising edge and samples the outputs 1 ns after the following edges. Each check sits at the edge count that this register chain gives, and the no-request cases are watched across several edges.

// File: rtl/pause_pkg.sv
package pause_pkg;
  localparam int PAUSE_W = 16;
  typedef enum logic {SRC_SW = 1'b0, SRC_AUTO = 1'b1} req_src_e;
endpackage

// File: rtl/pause_resend_timer.sv
module pause_resend_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             stop,
  input  logic             tick,
  input  logic [CNT_W-1:0] ivl,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;
  logic             armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (load) begin
      cnt   <= ivl;
      armed <= 1'b1;
    end else if (stop) begin
      armed <= 1'b0;
    end else if (armed && tick && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = armed && (cnt == '0);
endmodule

// File: rtl/pause_level_mon.sv
module pause_level_mon #(
  parameter int LVL_W = 8,
  parameter int CNT_W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         en,
  input  logic [LVL_W-1:0]             level,
  input  logic [LVL_W-1:0]             thr_on,
  input  logic [LVL_W-1:0]             thr_off,
  input  logic                         no_zero,
  input  logic [pause_pkg::PAUSE_W-1:0] pause_time,
  input  logic                         tick,
  input  logic [CNT_W-1:0]             ivl,
  output logic                         evt,
  output logic [pause_pkg::PAUSE_W-1:0] evt_time
);
  logic paused, expired, on_c, off_c, rs_c, above;

  assign above = level > thr_on;
  assign on_c  = en && !paused && above;
  assign off_c = en && paused && (level < thr_off);
  assign rs_c  = en && paused && !off_c && expired;

  pause_resend_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst),
    .load(on_c || rs_c), .stop(!en || off_c),
    .tick(tick), .ivl(ivl), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      paused   <= 1'b0;
      evt      <= 1'b0;
      evt_time <= '0;
    end else begin
      evt <= 1'b0;
      if (!en) begin
        paused <= 1'b0;
      end else if (on_c) begin
        paused   <= 1'b1;
        evt      <= 1'b1;
        evt_time <= pause_time;
      end else if (off_c) begin
        paused   <= 1'b0;
        evt      <= !no_zero;
        evt_time <= '0;
      end else if (rs_c && above) begin
        evt      <= 1'b1;
        evt_time <= pause_time;
      end
    end
  end
endmodule

// File: rtl/pause_req_arb.sv
module pause_req_arb (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          en,
  input  logic                          sw_trig,
  input  logic [pause_pkg::PAUSE_W-1:0] pause_time,
  input  logic                          auto_evt,
  input  logic [pause_pkg::PAUSE_W-1:0] auto_time,
  input  logic                          req_ack,
  output logic                          req_valid,
  output logic [pause_pkg::PAUSE_W-1:0] req_time,
  output logic                          sw_busy
);
  import pause_pkg::*;

  logic                sw_pend, auto_pend, sw_want, auto_want;
  logic [PAUSE_W-1:0]  auto_time_q, auto_t;
  req_src_e            src;

  logic                v_n, sp_n, ap_n, busy_n;
  logic [PAUSE_W-1:0]  t_n, at_n;
  req_src_e            src_n;

  assign sw_want   = en && (sw_trig || sw_pend);
  assign auto_want = en && (auto_evt || auto_pend);
  assign auto_t    = auto_evt ? auto_time : auto_time_q;

  always_comb begin
    v_n   = req_valid;
    t_n   = req_time;
    src_n = src;
    sp_n  = sw_want;
    ap_n  = auto_want;
    at_n  = auto_t;
    if (req_valid && req_ack) v_n = 1'b0;
    if (!req_valid) begin
      if (sw_want) begin
        v_n = 1'b1; t_n = pause_time; src_n = SRC_SW; sp_n = 1'b0;
      end else if (auto_want) begin
        v_n = 1'b1; t_n = auto_t; src_n = SRC_AUTO; ap_n = 1'b0;
      end
    end
    busy_n = sp_n || (v_n && src_n == SRC_SW);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid   <= 1'b0;
      req_time    <= '0;
      src         <= SRC_SW;
      sw_pend     <= 1'b0;
      auto_pend   <= 1'b0;
      auto_time_q <= '0;
      sw_busy     <= 1'b0;
    end else begin
      req_valid   <= v_n;
      req_time    <= t_n;
      src         <= src_n;
      sw_pend     <= sp_n;
      auto_pend   <= ap_n;
      auto_time_q <= at_n;
      sw_busy     <= busy_n;
    end
  end
endmodule

// File: rtl/pause_tx_ctrl.sv
module pause_tx_ctrl #(
  parameter int LVL_W    = 8,
  parameter int RESEND_W = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_fc_en,
  input  logic                          cfg_full_duplex,
  input  logic [pause_pkg::PAUSE_W-1:0] cfg_pause_time,
  input  logic [RESEND_W-1:0]           cfg_resend_ivl,
  input  logic [LVL_W-1:0]              cfg_thr_on,
  input  logic [LVL_W-1:0]              cfg_thr_off,
  input  logic                          cfg_no_zero,
  input  logic                          sw_trig,
  input  logic [LVL_W-1:0]              fifo_level,
  input  logic                          quanta_tick,
  input  logic                          req_ack,
  output logic                          req_valid,
  output logic [pause_pkg::PAUSE_W-1:0] req_time,
  output logic                          sw_busy
);
  logic                          en, auto_evt;
  logic [pause_pkg::PAUSE_W-1:0] auto_time;

  assign en = cfg_fc_en && cfg_full_duplex;

  pause_level_mon #(.LVL_W(LVL_W), .CNT_W(RESEND_W)) u_mon (
    .clk(clk), .rst(rst), .en(en), .level(fifo_level),
    .thr_on(cfg_thr_on), .thr_off(cfg_thr_off), .no_zero(cfg_no_zero),
    .pause_time(cfg_pause_time), .tick(quanta_tick), .ivl(cfg_resend_ivl),
    .evt(auto_evt), .evt_time(auto_time)
  );

  pause_req_arb u_arb (
    .clk(clk), .rst(rst), .en(en), .sw_trig(sw_trig),
    .pause_time(cfg_pause_time), .auto_evt(auto_evt), .auto_time(auto_time),
    .req_ack(req_ack), .req_valid(req_valid), .req_time(req_time),
    .sw_busy(sw_busy)
  );
endmodule

// File: rtl/pause_tx_ctrl_chk.sv
module pause_tx_ctrl_chk #(
  parameter int LVL_W = 8
) (
  input logic        clk,
  input logic        rst,
  input logic        cfg_fc_en,
  input logic        cfg_full_duplex,
  input logic [15:0] cfg_pause_time,
  input logic        sw_trig,
  input logic        req_ack,
  input logic        req_valid,
  input logic [15:0] req_time,
  input logic        sw_busy
);
  logic en;
  assign en = cfg_fc_en && cfg_full_duplex;

  p_gate_r1: assert property (@(posedge clk) disable iff (rst)
    (!en && !req_valid) |=> !req_valid);

  p_sw_next_r2: assert property (@(posedge clk) disable iff (rst)
    (sw_trig && en && !req_valid) |=> (req_valid && req_time == $past(cfg_pause_time)));

  p_busy_set_r8: assert property (@(posedge clk) disable iff (rst)
    (sw_trig && en) |=> sw_busy);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ack) |=> (req_valid && $stable(req_time)));

  p_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ack) |=> !req_valid);
endmodule

bind pause_tx_ctrl pause_tx_ctrl_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_fc_en(cfg_fc_en), .cfg_full_duplex(cfg_full_duplex),
  .cfg_pause_time(cfg_pause_time), .sw_trig(sw_trig), .req_ack(req_ack),
  .req_valid(req_valid), .req_time(req_time), .sw_busy(sw_busy)
);

// File: tb/tb_pause_tx_ctrl.sv
`timescale 1ns/1ps
module tb_pause_tx_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_fc_en, cfg_full_duplex, cfg_no_zero;
  logic [15:0] cfg_pause_time, cfg_resend_ivl;
  logic [7:0]  cfg_thr_on, cfg_thr_off, fifo_level;
  logic        sw_trig, quanta_tick, req_ack;
  logic        req_valid, sw_busy;
  logic [15:0] req_time;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pause_tx_ctrl #(.LVL_W(8), .RESEND_W(16)) dut (
    .clk(clk), .rst(rst), .cfg_fc_en(cfg_fc_en), .cfg_full_duplex(cfg_full_duplex),
    .cfg_pause_time(cfg_pause_time), .cfg_resend_ivl(cfg_resend_ivl),
    .cfg_thr_on(cfg_thr_on), .cfg_thr_off(cfg_thr_off), .cfg_no_zero(cfg_no_zero),
    .sw_trig(sw_trig), .fifo_level(fifo_level), .quanta_tick(quanta_tick),
    .req_ack(req_ack), .req_valid(req_valid), .req_time(req_time), .sw_busy(sw_busy)
  );

  // row: trig(1) level(8) ack(1) exp_valid(1) exp_busy(1) exp_time(16)
  localparam int NROW = 20;
  localparam logic [27:0] TBL [NROW] = '{
    {1'b1, 8'd0,  1'b0, 1'b1, 1'b1, 16'h1234}, // R2 trigger
    {1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 16'h0000}, // R10 ack drops
    {1'b1, 8'd0,  1'b0, 1'b1, 1'b1, 16'h1234},
    {1'b1, 8'd0,  1'b0, 1'b1, 1'b1, 16'h1234}, // R8 trig while outstanding
    {1'b0, 8'd0,  1'b1, 1'b0, 1'b1, 16'h0000}, // R8 still busy
    {1'b0, 8'd0,  1'b0, 1'b1, 1'b1, 16'h1234}, // R8 held trigger sent
    {1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 16'h0000},
    {1'b0, 8'd50, 1'b0, 1'b0, 1'b0, 16'h0000}, // R4 crossing
    {1'b0, 8'd50, 1'b0, 1'b1, 1'b0, 16'h1234}, // R4 auto frame
    {1'b0, 8'd50, 1'b1, 1'b0, 1'b0, 16'h0000},
    {1'b0, 8'd25, 1'b0, 1'b0, 1'b0, 16'h0000}, // R7 hold
    {1'b0, 8'd5,  1'b0, 1'b0, 1'b0, 16'h0000}, // R6 below off
    {1'b0, 8'd5,  1'b0, 1'b1, 1'b0, 16'h0000}, // R6 zero frame
    {1'b0, 8'd5,  1'b1, 1'b0, 1'b0, 16'h0000},
    {1'b0, 8'd25, 1'b0, 1'b0, 1'b0, 16'h0000}, // R7 hold unpaused
    {1'b1, 8'd41, 1'b0, 1'b1, 1'b1, 16'h1234}, // R9 both at once
    {1'b0, 8'd41, 1'b0, 1'b1, 1'b1, 16'h1234}, // R10 held
    {1'b0, 8'd41, 1'b1, 1'b0, 1'b0, 16'h0000},
    {1'b0, 8'd41, 1'b0, 1'b1, 1'b0, 16'h1234}, // R9 auto afterwards
    {1'b0, 8'd41, 1'b1, 1'b0, 1'b0, 16'h0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; sw_trig = 1'b0; req_ack = 1'b0; fifo_level = 8'd0; quanta_tick = 1'b0;
    step(); step();
    rst = 1'b0;
  endtask

  initial begin
    cfg_fc_en = 1'b1; cfg_full_duplex = 1'b1; cfg_no_zero = 1'b0;
    cfg_pause_time = 16'h1234; cfg_resend_ivl = 16'd2;
    cfg_thr_on = 8'd40; cfg_thr_off = 8'd10;
    #1;
    do_reset();
    check("reset req_valid", {31'd0, req_valid}, 32'd0);
    check("reset sw_busy", {31'd0, sw_busy}, 32'd0);

    for (int i = 0; i < NROW; i++) begin
      sw_trig = TBL[i][27]; fifo_level = TBL[i][26:19]; req_ack = TBL[i][18];
      step();
      check($sformatf("R2/R4/R6/R9/R10 row %0d valid", i), {31'd0, req_valid}, {31'd0, TBL[i][17]});
      check($sformatf("R8 row %0d busy", i), {31'd0, sw_busy}, {31'd0, TBL[i][16]});
      if (TBL[i][17]) check($sformatf("R3/R6 row %0d time", i), {16'd0, req_time}, {16'd0, TBL[i][15:0]});
    end
    sw_trig = 1'b0; req_ack = 1'b0;

    // R1: half duplex blocks everything
    do_reset();
    cfg_full_duplex = 1'b0;
    sw_trig = 1'b1; fifo_level = 8'd60;
    step(); sw_trig = 1'b0;
    for (int k = 0; k < 4; k++) begin
      step();
      check("R1 no request when disabled", {31'd0, req_valid}, 32'd0);
      check("R1 busy stays low", {31'd0, sw_busy}, 32'd0);
    end
    cfg_full_duplex = 1'b1;

    // R3: software frame with zero time
    do_reset();
    cfg_pause_time = 16'h0000;
    sw_trig = 1'b1; step(); sw_trig = 1'b0;
    check("R3 zero-time valid", {31'd0, req_valid}, 32'd1);
    check("R3 zero-time value", {16'd0, req_time}, 32'd0);
    req_ack = 1'b1; step(); req_ack = 1'b0;
    cfg_pause_time = 16'h1234;

    // R5: resend after interval
    do_reset();
    quanta_tick = 1'b1; fifo_level = 8'd60;
    step();
    step(); check("R5 first pause", {31'd0, req_valid}, 32'd1);
    req_ack = 1'b1; step(); req_ack = 1'b0;
    check("R5 acked", {31'd0, req_valid}, 32'd0);
    step(); check("R5 not yet", {31'd0, req_valid}, 32'd0);
    step(); check("R5 resend valid", {31'd0, req_valid}, 32'd1);
    check("R5 resend time", {16'd0, req_time}, 32'h1234);
    req_ack = 1'b1; step(); req_ack = 1'b0;
    fifo_level = 8'd25;
    for (int k = 0; k < 5; k++) begin
      step();
      check("R5/R7 no resend between thresholds", {31'd0, req_valid}, 32'd0);
    end

    // R6: zero frame suppressed, state still leaves pause
    quanta_tick = 1'b0; cfg_no_zero = 1'b1; fifo_level = 8'd0;
    for (int k = 0; k < 4; k++) begin
      step();
      check("R6 zero frame suppressed", {31'd0, req_valid}, 32'd0);
    end
    fifo_level = 8'd60;
    step(); step();
    check("R6 unpaused so new pause", {31'd0, req_valid}, 32'd1);
    check("R6 new pause time", {16'd0, req_time}, 32'h1234);
    req_ack = 1'b1; step(); req_ack = 1'b0;
    cfg_no_zero = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int w = 0; w < 100000; w++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule